// File: doc/BRIEF.md
# Telephony Codec Serial Link

This block sits between a host bus and an external telephony codec. It runs a full-duplex serial link carrying one byte per slot in each direction. It derives the bit clock from the system clock and marks each 8-bit slot with a frame pulse. Outgoing bytes are taken from a 16-entry transmit queue and shifted out. Incoming bits are assembled into bytes and placed in a 16-entry receive queue.

The receive and transmit directions have separate enable inputs. They share one timing engine, which runs while either direction is enabled and is held idle while both are off. The engine counts completed slots and raises an interrupt once every eight of them. The host services the interrupt by writing eight bytes and reading eight bytes, then acknowledges it. In the real system the divider is set for 64 kbit/s per direction, so the interrupt falls due once per millisecond.

Top module: `codec_link`

## Requirements
- R1: `bitClk` has a period of 2*HALF_DIV system clocks while either enable is high. It is held low while both enables are low.
- R2: `frameSync` is high for exactly the first bit period of every 8-bit slot and low for the other seven. It rises together with a rising edge of `bitClk`.
- R3: Transmit bytes leave in the order they were written, most significant bit first. `sdo` changes only on rising edges of `bitClk`.
- R4: The block samples `sdi` on falling edges of `bitClk`, most significant bit first. Each complete byte enters the receive queue in arrival order. The host reads the oldest byte on `rdData` and removes it with a one-cycle `rdEn` pulse.
- R5: Each queue holds 16 bytes. `txFull` is high once 16 bytes wait in the transmit queue, and a write while it is full is dropped.
- R6: If the transmit queue is empty at the start of a slot, the byte sent is 0x00 and `txUnderflow` is set. `txUnderflow` stays set until `txEn` falls.
- R7: A received byte that finds the receive queue full is dropped, the stored bytes are kept, and `rxOverflow` is set. `rxOverflow` stays set until `rxEn` falls.
- R8: `irq` is set at the end of every eighth slot. The first one comes 128*HALF_DIV system clocks after the first enable rises, even if the other direction is enabled later.
- R9: Once set, `irq` stays high until an `irqAck` pulse, or until both enables are low.
- R10: A direction whose enable is low has its queue flushed, and host writes to the transmit queue while `txEn` is low are ignored. While both enables are low, `rxEmpty` reads 1 and `txFull` reads 0.
- R11: `sdoEn` follows `txEn`, and `sdo` is 0 while `txEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEn | input | 1 | Receive direction enable |
| txEn | input | 1 | Transmit direction enable |
| wrEn | input | 1 | Push `wrData` into the transmit queue |
| wrData | input | 8 | Byte to transmit |
| rdEn | input | 1 | Pop the oldest received byte |
| rdData | output | 8 | Oldest received byte |
| rxEmpty | output | 1 | Receive queue empty |
| txFull | output | 1 | Transmit queue full |
| txUnderflow | output | 1 | Sticky: a slot was sent with no data |
| rxOverflow | output | 1 | Sticky: a received byte was dropped |
| irq | output | 1 | Eight-slot interrupt |
| irqAck | input | 1 | Clears `irq` |
| bitClk | output | 1 | Serial bit clock to the codec |
| frameSync | output | 1 | Slot start pulse, one bit period wide |
| sdo | output | 1 | Serial data to the codec |
| sdoEn | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data from the codec |

## Verification
The serial path is driven with a table of byte pairs: 0x00, 0xFF, single-bit values at either end, alternating patterns and asymmetric values. An all-zero or all-one byte shows whether bits are present at all. A lone top or bottom bit shows whether the bit order is reversed. The asymmetric values show whether bits are shifted one place or whether transmit and receive are crossed.

The directed runs cover the following:
- Transmit-only traffic past the queue depth, which tells a dropped write apart from an overwritten entry.
- Receive-only traffic past the queue depth, which tells a dropped byte apart from a lost old one.
- A late second enable, which shows whether the interrupt timer restarts when the other direction comes up.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;
  // One-cycle strobes from the timing engine to the datapath
  typedef struct packed {
    logic bitRise;    // bitClk goes high at this edge
    logic bitFall;    // bitClk goes low at this edge
    logic slotStart;  // rising edge that opens a new slot
    logic slotEnd;    // falling edge that samples the last bit of a slot
  } linkStrobes_t;
endpackage

// File: rtl/codec_link_fifo.sv
module codec_link_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doWr, doRd;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign doWr  = push && !full;
  assign doRd  = pop && !empty;
  assign dout  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (doRd) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      if (doWr && !doRd) count <= count + CNT_W'(1);
      else if (doRd && !doWr) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= din;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !clr) |=> (full && count == $past(count)));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> empty);
endmodule

// File: rtl/codec_link_ctrl.sv
module codec_link_ctrl
  import codec_link_pkg::*;
#(
  parameter int HALF_DIV      = 2,
  parameter int SLOT_BITS     = 8,
  parameter int SLOTS_PER_IRQ = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         active,
  input  logic         irqAck,
  output linkStrobes_t strb,
  output logic         bitClk,
  output logic         frameSync,
  output logic         irq
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int POS_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam int CNT_W = (SLOTS_PER_IRQ > 1) ? $clog2(SLOTS_PER_IRQ) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] bitPos;
  logic [CNT_W-1:0] slotCnt;
  logic             started, divWrap, lastBit, irqDue;

  assign divWrap = (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastBit = (bitPos == POS_W'(SLOT_BITS - 1));
  assign irqDue  = (slotCnt == CNT_W'(SLOTS_PER_IRQ - 1));

  always_comb begin
    strb.bitRise   = active && divWrap && !bitClk;
    strb.bitFall   = active && divWrap && bitClk;
    strb.slotStart = strb.bitRise && (!started || lastBit);
    strb.slotEnd   = strb.bitFall && started && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; bitClk <= 1'b0; started <= 1'b0; bitPos <= '0;
      frameSync <= 1'b0; slotCnt <= '0; irq <= 1'b0;
    end else if (!active) begin
      divCnt <= '0; bitClk <= 1'b0; started <= 1'b0; bitPos <= '0;
      frameSync <= 1'b0; slotCnt <= '0; irq <= 1'b0;
    end else begin
      divCnt <= divWrap ? '0 : divCnt + DIV_W'(1);
      if (divWrap) bitClk <= !bitClk;
      if (strb.bitRise) begin
        started   <= 1'b1;
        bitPos    <= strb.slotStart ? '0 : bitPos + POS_W'(1);
        frameSync <= strb.slotStart;
      end
      if (strb.slotEnd) slotCnt <= irqDue ? '0 : slotCnt + CNT_W'(1);
      if (strb.slotEnd && irqDue) irq <= 1'b1;
      else if (irqAck)            irq <= 1'b0;
    end
  end

  // R1
  bitclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!bitClk && !frameSync));

  // R2
  fsync_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSync) |-> $rose(bitClk));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && irq && !irqAck) |=> irq);
endmodule

// File: rtl/codec_link_dp.sv
module codec_link_dp
  import codec_link_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  linkStrobes_t strb,
  input  logic         rxEn,
  input  logic         txEn,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  input  logic         sdi,
  output logic [W-1:0] rdData,
  output logic         rxEmpty,
  output logic         txFull,
  output logic         txUnderflow,
  output logic         rxOverflow,
  output logic         sdo
);
  logic [W-1:0] txHead, txShift, rxShift, rxByte;
  logic         txEmptyRaw, txFullRaw, rxEmptyRaw, rxFullRaw, bothOff;
  logic         txPop, rxPush;

  assign bothOff = !rxEn && !txEn;
  assign txPop   = txEn && strb.slotStart;
  assign rxByte  = {rxShift[W-2:0], sdi};
  assign rxPush  = rxEn && strb.slotEnd;

  codec_link_fifo #(.DEPTH(DEPTH), .W(W)) u_txFifo (
    .clk(clk), .rstN(rstN), .clr(!txEn), .push(wrEn && txEn), .din(wrData),
    .pop(txPop), .dout(txHead), .empty(txEmptyRaw), .full(txFullRaw));

  codec_link_fifo #(.DEPTH(DEPTH), .W(W)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clr(!rxEn), .push(rxPush), .din(rxByte),
    .pop(rdEn), .dout(rdData), .empty(rxEmptyRaw), .full(rxFullRaw));

  assign rxEmpty = bothOff || rxEmptyRaw;
  assign txFull  = !bothOff && txFullRaw;
  assign sdo     = txShift[W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0; txUnderflow <= 1'b0;
    end else if (!txEn) begin
      txShift <= '0; txUnderflow <= 1'b0;
    end else if (strb.slotStart) begin
      txShift <= txEmptyRaw ? '0 : txHead;
      if (txEmptyRaw) txUnderflow <= 1'b1;
    end else if (strb.bitRise) begin
      txShift <= {txShift[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0; rxOverflow <= 1'b0;
    end else if (!rxEn) begin
      rxShift <= '0; rxOverflow <= 1'b0;
    end else begin
      if (strb.bitFall) rxShift <= rxByte;
      if (rxPush && rxFullRaw) rxOverflow <= 1'b1;
    end
  end

  // R6
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && txEmptyRaw) |=> (!sdo && txUnderflow));

  // R7
  overflow_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFullRaw && !rdEn) |=> (rxOverflow && !rxEmptyRaw));
endmodule

// File: rtl/codec_link.sv
module codec_link #(
  parameter int HALF_DIV      = 2,
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 16,
  parameter int SLOTS_PER_IRQ = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              txEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rxEmpty,
  output logic              txFull,
  output logic              txUnderflow,
  output logic              rxOverflow,
  output logic              irq,
  input  logic              irqAck,
  output logic              bitClk,
  output logic              frameSync,
  output logic              sdo,
  output logic              sdoEn,
  input  logic              sdi
);
  codec_link_pkg::linkStrobes_t strb;

  codec_link_ctrl #(.HALF_DIV(HALF_DIV), .SLOT_BITS(DATA_W),
                    .SLOTS_PER_IRQ(SLOTS_PER_IRQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .active(rxEn || txEn), .irqAck(irqAck),
    .strb(strb), .bitClk(bitClk), .frameSync(frameSync), .irq(irq));

  codec_link_dp #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxEn(rxEn), .txEn(txEn),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .sdi(sdi), .rdData(rdData),
    .rxEmpty(rxEmpty), .txFull(txFull), .txUnderflow(txUnderflow),
    .rxOverflow(rxOverflow), .sdo(sdo));

  assign sdoEn = txEn;

  // R11
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> !sdo);
endmodule

// File: tb/codec_link_bench.sv
module codec_link_bench;
  localparam int HALF = 2;
  localparam int IRQ_CYC = 128 * HALF;
  // {txByte, rxByte}
  localparam logic [15:0] VEC [8] = '{
    16'hA5_3C, 16'h01_80, 16'hFF_00, 16'h00_FF,
    16'h80_01, 16'h5A_C3, 16'h7E_81, 16'h12_ED };

  logic clk = 0, rstN = 0, rxEn = 0, txEn = 0, wrEn = 0, rdEn = 0, irqAck = 0, sdi = 0;
  logic [7:0] wrData = 0, rdData;
  logic rxEmpty, txFull, txUnderflow, rxOverflow, irq, bitClk, frameSync, sdo, sdoEn;

  always #2 clk = ~clk;

  codec_link #(.HALF_DIV(HALF)) u_codec_link (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .txEn(txEn), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .rxEmpty(rxEmpty), .txFull(txFull),
    .txUnderflow(txUnderflow), .rxOverflow(rxOverflow), .irq(irq), .irqAck(irqAck),
    .bitClk(bitClk), .frameSync(frameSync), .sdo(sdo), .sdoEn(sdoEn), .sdi(sdi));

  int checks = 0, fails = 0;
  int cyc, riseIdx, slot, lastRise, wrN, wrPos;
  logic prevClk;
  logic [7:0] txCap [32];
  logic [7:0] rxSrc [32];
  logic [7:0] wrBuf [32];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic startLink();
    cyc = 0; riseIdx = -1; slot = -1; lastRise = -1; prevClk = 0; wrPos = 0;
    for (int i = 0; i < 32; i++) txCap[i] = 8'hxx;
  endtask

  // Advance n cycles, acting as the codec on the serial pins
  task automatic runLink(input int n);
    for (int k = 0; k < n; k++) begin
      if (wrPos < wrN) begin wrEn = 1; wrData = wrBuf[wrPos]; wrPos++; end
      else wrEn = 0;
      @(negedge clk);
      cyc++;
      if (bitClk && !prevClk) begin
        riseIdx++;
        if (riseIdx % 8 == 0) slot++;
        // R2 frame pulse on first bit only
        check(frameSync == (riseIdx % 8 == 0), "R2 frameSync", frameSync, riseIdx % 8 == 0);
        // R1 bit period
        if (lastRise >= 0 && riseIdx % 8 == 1)
          check(cyc - lastRise == 2 * HALF, "R1 bitClk period", cyc - lastRise, 2 * HALF);
        lastRise = cyc;
        if (slot < 32) begin
          txCap[slot][7 - riseIdx % 8] = sdo;
          sdi = rxSrc[slot][7 - riseIdx % 8];
        end
      end
      prevClk = bitClk;
    end
    wrEn = 0;
  endtask

  task automatic readByte(output logic [7:0] v);
    v = rdData; rdEn = 1;
    @(negedge clk);
    rdEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wrN = 0; wrPos = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!bitClk && !frameSync, "R1 reset idle bitClk", bitClk, 0);
    check(rxEmpty && !txFull, "R10 reset flags", {rxEmpty, txFull}, 2'b10);
    check(!irq, "R9 reset irq", irq, 0);
    check(!sdoEn && !sdo, "R11 reset sdoEn", sdoEn, 0);

    // R10: write while disabled must be ignored
    wrEn = 1; wrData = 8'h77;
    @(negedge clk);
    wrEn = 0;
    @(negedge clk);
    check(!txFull && !bitClk, "R10 disabled write", txFull, 0);

    // Table-driven main run: both directions, 8 slots
    startLink();
    for (int i = 0; i < 8; i++) begin wrBuf[i] = VEC[i][15:8]; rxSrc[i] = VEC[i][7:0]; end
    for (int i = 8; i < 32; i++) rxSrc[i] = 8'h00;
    wrN = 8;
    rxEn = 1; txEn = 1;
    runLink(IRQ_CYC - 1);
    check(!irq, "R8 irq early", irq, 0);
    runLink(1);
    check(irq, "R8 irq at 8 slots", irq, 1);
    runLink(4);
    check(irq, "R9 irq held", irq, 1);
    for (int i = 0; i < 8; i++)
      check(txCap[i] == VEC[i][15:8], "R3 tx byte order", txCap[i], VEC[i][15:8]);
    check(txCap[0] != 8'h77, "R10 ignored write not sent", txCap[0], VEC[0][15:8]);
    check(txUnderflow && !sdo, "R6 underflow sends zero", {txUnderflow, sdo}, 2'b10);
    for (int i = 0; i < 8; i++) begin
      readByte(v);
      check(v == VEC[i][7:0], "R4 rx byte", v, VEC[i][7:0]);
    end
    check(rxEmpty, "R4 rx drained", rxEmpty, 1);
    irqAck = 1;
    @(negedge clk);
    irqAck = 0;
    check(!irq, "R9 irq ack", irq, 0);
    rxEn = 0; txEn = 0;
    repeat (2) @(negedge clk);
    check(rxEmpty && !txFull, "R10 idle flags", {rxEmpty, txFull}, 2'b10);
    check(!bitClk && !irq, "R1 idle after disable", bitClk, 0);
    check(!sdoEn && !txUnderflow, "R11 sdoEn off", {sdoEn, txUnderflow}, 0);

    // R8: late transmit enable does not restart timer
    startLink(); wrN = 0;
    rxEn = 1;
    runLink(50);
    check(!sdoEn && !sdo, "R11 sdoEn while tx off", sdoEn, 0);
    runLink(50);
    txEn = 1;
    runLink(1);
    check(sdoEn, "R11 sdoEn on", sdoEn, 1);
    runLink(IRQ_CYC - 102);
    check(!irq, "R8 late enable early", irq, 0);
    runLink(1);
    check(irq, "R8 late enable irq", irq, 1);
    rxEn = 0; txEn = 0;
    repeat (2) @(negedge clk);

    // R5: transmit queue full, extra writes dropped
    startLink();
    for (int i = 0; i < 20; i++) wrBuf[i] = 8'(i + 1);
    wrN = 20;
    txEn = 1;
    runLink(21);
    check(txFull, "R5 txFull", txFull, 1);
    runLink(560);
    check(txCap[16] == 8'd17, "R5 last accepted", txCap[16], 17);
    check(txCap[17] == 8'h00, "R5 dropped write", txCap[17], 0);
    txEn = 0;
    repeat (2) @(negedge clk);
    check(!txFull, "R10 tx flush", txFull, 1'b0);

    // R7: receive overflow keeps old bytes
    startLink(); wrN = 0;
    for (int i = 0; i < 32; i++) rxSrc[i] = 8'(8'h40 + i);
    rxEn = 1;
    runLink(545);
    check(rxOverflow && !rxEmpty, "R7 overflow flag", rxOverflow, 1);
    check(!sdoEn && !sdo, "R11 rx only sdo quiet", sdo, 0);
    readByte(v);
    check(v == 8'h40, "R7 oldest kept", v, 8'h40);
    for (int i = 1; i < 16; i++) readByte(v);
    check(v == 8'h4F, "R7 last stored", v, 8'h4F);
    check(rxEmpty, "R7 newer byte dropped", rxEmpty, 1);
    rxEn = 0;
    repeat (2) @(negedge clk);
    check(!rxOverflow, "R7 sticky cleared", rxOverflow, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule